// File: doc/BRIEF.md
# RTC Power-On Wake Controller

This block decides when the real-time-clock domain should ask the system to turn main power on. It drives an active-low power-on request, modelled as an open-drain pad: a level output plus a separate drive enable. When the drive enable is low, the pad floats and main power stays off. Three conditions move the pad. A standby power-on-reset pulse can either force the request on or force the pad to float, depending on two configuration bits. An alarm match that arrives while standby power is absent can be remembered, and it requests power-up when standby power comes back. A host acknowledge releases the request and clears the remembered alarm.

An 8-bit control register holds the three wake controls and a crystal load select. The crystal select is brought out as a static level. Four bits of the register are reserved, and they always read zero. Every decision is registered, so the pad changes one clock edge after the event that caused it.

Top module: `rtc_wake_ctrl`

## Requirements
- R1: After reset, or while reset is asserted, the register reads 0x00, pwr_on_oe_o is 0, pwr_on_n_o is 1 and xtal_sel_o is 0.
- R2: A write stores wdata bits 0, 1, 2 and 7, which read back at the same positions on the edge after the write. Bits 3 to 6 always read 0 and ignore writes, so writing 0xFF reads back 0x87.
- R3: xtal_sel_o equals register bit 7, where 0 selects the 12 pF load and 1 selects the 6 pF load.
- R4: If register bit 0 (remember enable) is 1 and alarm_hit_i is sampled while sby_ok_i is 0, a wake is latched. On the first edge where sby_ok_i is sampled 1 again, the pad is driven low (pwr_on_oe_o=1, pwr_on_n_o=0).
- R5: An alarm sampled while sby_ok_i is 1, or while bit 0 is 0, latches nothing. A later loss and return of standby power leaves the pad floating.
- R6: A sby_por_i pulse with bit 2 set and bit 1 clear drives the pad low on the next edge.
- R7: A sby_por_i pulse with bit 1 set floats the pad on the next edge, even if the pad was being driven.
- R8: If bits 1 and 2 are both set, a sby_por_i pulse floats the pad, because the off control wins.
- R9: A sby_por_i pulse with bits 1 and 2 both clear leaves the pad unchanged.
- R10: wake_ack_i floats the pad and clears a latched wake. In the same cycle, a sby_por_i pulse overrides the acknowledge. The acknowledge overrides the return of standby power.
- R11: A latched wake is kept through any length of power absence, even if bit 0 is cleared afterwards, until the acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register contents, with the reserved bits at zero |
| sby_ok_i | input | 1 | Standby power valid |
| sby_por_i | input | 1 | Standby power-on-reset pulse |
| alarm_hit_i | input | 1 | Alarm match event |
| wake_ack_i | input | 1 | Host acknowledge: releases the pad and clears a latched wake |
| pwr_on_n_o | output | 1 | Power-on request level, active low |
| pwr_on_oe_o | output | 1 | Pad drive enable; 0 means the pad floats |
| xtal_sel_o | output | 1 | Crystal load select, 1 for 6 pF |

## Verification
The latched wake has no port of its own. A wrong value in it shows only when standby power returns: the pad either fails to go low, or goes low without cause, on the edge where sby_ok_i is first sampled high. The bench therefore checks this latch through power cycles, including long gaps and a cleared enable. A wrong pad state shows one edge after a power-on-reset pulse or an acknowledge. A wrong register bit shows at once on the read port and on the crystal select.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
  localparam int CfgW      = 8;
  localparam int BitRem    = 0;
  localparam int BitPorOff = 1;
  localparam int BitPorOn  = 2;
  localparam int BitXtal   = 7;
  localparam logic [CfgW-1:0] CfgMask =
    CfgW'((1 << BitRem) | (1 << BitPorOff) | (1 << BitPorOn) | (1 << BitXtal));

  typedef struct packed {
    logic xtal_6pf;
    logic por_on;
    logic por_off;
    logic rem_en;
  } wake_cfg_t;

  typedef enum logic {
    DRV_FLOAT = 1'b0,
    DRV_LOW   = 1'b1
  } drv_e;
endpackage

// File: rtl/rtc_wake_cfg.sv
module rtc_wake_cfg
  import rtc_wake_pkg::*;
#(
  parameter int              W    = CfgW,
  parameter logic [W-1:0]    MASK = CfgMask
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output wake_cfg_t         cfg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i & MASK;
  end

  assign rdata_o        = cfg_q;
  assign cfg_o.rem_en   = cfg_q[BitRem];
  assign cfg_o.por_off  = cfg_q[BitPorOff];
  assign cfg_o.por_on   = cfg_q[BitPorOn];
  assign cfg_o.xtal_6pf = cfg_q[BitXtal];

  // R2
  wr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o == ($past(wdata_i) & MASK)));
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/rtc_wake_pend.sv
module rtc_wake_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rem_en_i,
  input  logic sby_ok_i,
  input  logic alarm_i,
  input  logic ack_i,
  output logic pend_o,
  output logic pwr_back_o
);
  logic pend_q, ok_q;
  logic set_pend;

  assign set_pend = alarm_i && !sby_ok_i && rem_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      ok_q <= sby_ok_i;
      if (set_pend)   pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign pend_o     = pend_q;
  assign pwr_back_o = sby_ok_i && !ok_q;

  // R4
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i && !sby_ok_i && rem_en_i) |=> pend_o);
  // R5
  pend_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && (sby_ok_i || !rem_en_i)) |=> !pend_o);
  // R10
  pend_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !alarm_i) |=> !pend_o);
  // R11
  pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/rtc_wake_drive.sv
module rtc_wake_drive
  import rtc_wake_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic por_off_i,
  input  logic por_on_i,
  input  logic ack_i,
  input  logic pend_i,
  input  logic pwr_back_i,
  output logic pwr_on_n_o,
  output logic pwr_on_oe_o
);
  drv_e drv_q, drv_d;

  // Off control wins over on control; a reset pulse outranks the acknowledge.
  always_comb begin
    drv_d = drv_q;
    if (por_i && por_off_i)         drv_d = DRV_FLOAT;
    else if (por_i && por_on_i)     drv_d = DRV_LOW;
    else if (ack_i)                 drv_d = DRV_FLOAT;
    else if (pend_i && pwr_back_i)  drv_d = DRV_LOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= DRV_FLOAT;
    else         drv_q <= drv_d;
  end

  assign pwr_on_oe_o = (drv_q == DRV_LOW);
  assign pwr_on_n_o  = (drv_q != DRV_LOW);

  // R7 R8
  por_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i && por_off_i) |=> !pwr_on_oe_o);
  // R6
  por_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i && por_on_i && !por_off_i) |=> (pwr_on_oe_o && !pwr_on_n_o));
  // R9
  por_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i && !por_on_i && !por_off_i && !ack_i && !(pend_i && pwr_back_i))
    |=> $stable(pwr_on_oe_o));
  // R4
  wake_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && pwr_back_i && !por_i && !ack_i) |=> pwr_on_oe_o);
  // R10
  ack_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !por_i) |=> (!pwr_on_oe_o && pwr_on_n_o));
endmodule

// File: rtl/rtc_wake_ctrl.sv
module rtc_wake_ctrl
  import rtc_wake_pkg::*;
#(
  parameter int W = CfgW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [W-1:0] cfg_wdata_i,
  output logic [W-1:0] cfg_rdata_o,
  input  logic         sby_ok_i,
  input  logic         sby_por_i,
  input  logic         alarm_hit_i,
  input  logic         wake_ack_i,
  output logic         pwr_on_n_o,
  output logic         pwr_on_oe_o,
  output logic         xtal_sel_o
);
  wake_cfg_t cfg;
  logic      pend, pwr_back;

  rtc_wake_cfg #(.W(W), .MASK(W'(CfgMask))) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  rtc_wake_pend u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rem_en_i   (cfg.rem_en),
    .sby_ok_i   (sby_ok_i),
    .alarm_i    (alarm_hit_i),
    .ack_i      (wake_ack_i),
    .pend_o     (pend),
    .pwr_back_o (pwr_back)
  );

  rtc_wake_drive u_drive (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_i       (sby_por_i),
    .por_off_i   (cfg.por_off),
    .por_on_i    (cfg.por_on),
    .ack_i       (wake_ack_i),
    .pend_i      (pend),
    .pwr_back_i  (pwr_back),
    .pwr_on_n_o  (pwr_on_n_o),
    .pwr_on_oe_o (pwr_on_oe_o)
  );

  assign xtal_sel_o = cfg.xtal_6pf;

  // R3
  xtal_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (xtal_sel_o == $past(cfg_wdata_i[BitXtal])));
endmodule

// File: tb/rtc_wake_ctrl_test.sv
`timescale 1ns/1ps
module rtc_wake_ctrl_test;
  localparam int VW = 26;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       sby_ok_i = 1'b0, sby_por_i = 1'b0, alarm_hit_i = 1'b0, wake_ack_i = 1'b0;
  logic       pwr_on_n_o, pwr_on_oe_o, xtal_sel_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rtc_wake_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .sby_ok_i(sby_ok_i), .sby_por_i(sby_por_i),
    .alarm_hit_i(alarm_hit_i), .wake_ack_i(wake_ack_i), .pwr_on_n_o(pwr_on_n_o),
    .pwr_on_oe_o(pwr_on_oe_o), .xtal_sel_o(xtal_sel_o)
  );

  function automatic logic [VW-1:0] mkv(input logic [3:0] rq, input logic we,
      input logic [7:0] wd, input logic ok, input logic por, input logic alm,
      input logic ack, input logic eo, input logic [7:0] erd);
    return {rq, we, wd, ok, por, alm, ack, eo, erd};
  endfunction

  // Each step: drive inputs, one edge, then compare pad and register.
  localparam int NV = 23;
  localparam logic [VW-1:0] VEC [NV] = '{
    mkv(2,  1, 8'hFF, 1, 0, 0, 0, 0, 8'h87), // R2 reserved bits dropped
    mkv(2,  1, 8'h01, 1, 0, 0, 0, 0, 8'h01),
    mkv(4,  0, 8'h00, 0, 0, 0, 0, 0, 8'h01),
    mkv(4,  0, 8'h00, 0, 0, 1, 0, 0, 8'h01), // R4 alarm while absent
    mkv(4,  0, 8'h00, 0, 0, 0, 0, 0, 8'h01),
    mkv(4,  0, 8'h00, 1, 0, 0, 0, 1, 8'h01), // R4 power back
    mkv(10, 0, 8'h00, 1, 0, 0, 1, 0, 8'h01), // R10 ack releases
    mkv(10, 0, 8'h00, 0, 0, 0, 0, 0, 8'h01),
    mkv(10, 0, 8'h00, 1, 0, 0, 0, 0, 8'h01), // R10 latch cleared
    mkv(5,  0, 8'h00, 1, 0, 1, 0, 0, 8'h01), // R5 alarm while powered
    mkv(5,  0, 8'h00, 0, 0, 0, 0, 0, 8'h01),
    mkv(5,  0, 8'h00, 1, 0, 0, 0, 0, 8'h01),
    mkv(2,  1, 8'h04, 1, 0, 0, 0, 0, 8'h04),
    mkv(6,  0, 8'h00, 1, 1, 0, 0, 1, 8'h04), // R6
    mkv(2,  1, 8'h00, 1, 0, 0, 0, 1, 8'h00),
    mkv(9,  0, 8'h00, 1, 1, 0, 0, 1, 8'h00), // R9 stays driven
    mkv(2,  1, 8'h02, 1, 0, 0, 0, 1, 8'h02),
    mkv(7,  0, 8'h00, 1, 1, 0, 0, 0, 8'h02), // R7
    mkv(2,  1, 8'h04, 1, 0, 0, 0, 0, 8'h04),
    mkv(6,  0, 8'h00, 1, 1, 0, 0, 1, 8'h04),
    mkv(2,  1, 8'h06, 1, 0, 0, 0, 1, 8'h06),
    mkv(8,  0, 8'h00, 1, 1, 0, 0, 0, 8'h06), // R8 off wins
    mkv(3,  1, 8'h80, 1, 0, 0, 0, 0, 8'h80)  // R3
  };

  task automatic step(input logic we, input logic [7:0] wd, input logic ok,
                      input logic por, input logic alm, input logic ack);
    @(negedge clk);
    cfg_we_i = we; cfg_wdata_i = wd; sby_ok_i = ok;
    sby_por_i = por; alarm_hit_i = alm; wake_ack_i = ack;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int rq, input logic eo, input logic [7:0] erd);
    n_chk++;
    if (pwr_on_oe_o !== eo || pwr_on_n_o !== !eo) begin
      n_fail++;
      $display("FAIL R%0d pad: oe=%b n=%b expected oe=%b n=%b", rq, pwr_on_oe_o, pwr_on_n_o, eo, !eo);
    end
    n_chk++;
    if (cfg_rdata_o !== erd) begin
      n_fail++;
      $display("FAIL R%0d rdata: actual=%h expected=%h", rq, cfg_rdata_o, erd);
    end
    n_chk++;
    if (xtal_sel_o !== erd[7]) begin
      n_fail++;
      $display("FAIL R3 xtal_sel: actual=%b expected=%b", xtal_sel_o, erd[7]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1, 1'b0, 8'h00);              // R1 during reset
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 check(1, 1'b0, 8'h00); // R1 after reset

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[21], v[20:13], v[12], v[11], v[10], v[9]);
      check(int'(v[25:22]), v[8], v[7:0]);
    end

    // R10: reset pulse outranks acknowledge
    step(1, 8'h04, 1, 0, 0, 0); check(10, 0, 8'h04);
    step(0, 8'h00, 1, 1, 0, 1); check(10, 1, 8'h04);
    step(0, 8'h00, 1, 0, 0, 1); check(10, 0, 8'h04);

    // R11: latch survives long absence and a cleared enable
    step(1, 8'h01, 0, 0, 0, 0); check(11, 0, 8'h01);
    step(0, 8'h00, 0, 0, 1, 0); check(11, 0, 8'h01);
    step(1, 8'h00, 0, 0, 0, 0); check(11, 0, 8'h00);
    for (int k = 0; k < 40; k++) step(0, 8'h00, 0, 0, 0, 0);
    check(11, 0, 8'h00);
    step(0, 8'h00, 1, 0, 0, 0); check(11, 1, 8'h00);
    step(0, 8'h00, 1, 0, 0, 1); check(11, 0, 8'h00);

    // R10: acknowledge outranks power return
    step(1, 8'h01, 0, 0, 0, 0); check(10, 0, 8'h01);
    step(0, 8'h00, 0, 0, 1, 0); check(10, 0, 8'h01);
    step(0, 8'h00, 1, 0, 0, 1); check(10, 0, 8'h01);
    step(0, 8'h00, 0, 0, 0, 0); check(10, 0, 8'h01);
    step(0, 8'h00, 1, 0, 0, 0); check(10, 0, 8'h01);

    // R1: asynchronous reset while driving
    step(1, 8'h84, 1, 0, 0, 0); check(1, 0, 8'h84);
    step(0, 8'h00, 1, 1, 0, 0); check(1, 1, 8'h84);
    @(negedge clk); sby_por_i = 1'b0; #1 rst_ni = 1'b0;
    #1 check(1, 0, 8'h00);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 check(1, 0, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule